// File: doc/BRIEF.md
# Receive Frame Status and Interrupt Unit

This unit follows each Ethernet frame arriving as a stream of bytes and builds the status that is written into the frame's receive buffer descriptor. A frame opens with a start marker on its first byte and closes with an end marker on its last byte. Every byte in between is counted, and the count saturates instead of wrapping. A frame longer than the programmed maximum is never cut short. All of its bytes are still counted, and the first byte past the limit raises a babbling-receiver event and sets the long-frame flag.

When the frame ends, the unit hands the descriptor back in three fixed steps. In the first cycle it writes the status (length, last flag, long flag). In the second it releases ownership by clearing the empty bit. In the third it raises the frame-received event. It then waits for the next frame. The two events are sticky and are cleared by writing a one to them. A single interrupt line reports every event whose mask bit is set.

Top module: `rx_frame_status`

## Requirements
- R1: After reset, `st_wr`, `own_rel`, `st_last`, `st_long`, `events` and `irq` are all 0, and `st_len` is 0.
- R2: A byte with `rx_dv` and `rx_sof` both high starts a new frame with a count of 1. This also applies in the middle of a frame. Each further `rx_dv` byte in the frame adds 1. An `rx_dv` outside a frame without `rx_sof` is ignored. `st_len` shows the current count.
- R3: Bytes beyond `max_len` are still counted, so the reported length is the true byte count.
- R4: The byte that takes the count from `max_len` to `max_len`+1 sets `st_long` and event bit 0 (babbling receiver). Later bytes of the same frame do not set bit 0 again, even after it has been cleared. A frame of exactly `max_len` bytes leaves both at 0.
- R5: The count saturates at 2^LEN_W-1. A frame that reaches this value never raises bit 0, even when `max_len` equals that value.
- R6: In the cycle after the byte carrying `rx_eof`, `st_wr` and `st_last` are high for exactly one cycle, with `st_len` and `st_long` valid.
- R7: In the cycle after `st_wr`, `own_rel` (empty-bit clear) is high for exactly one cycle.
- R8: Event bit 1 (frame received) reads 1 starting in the cycle after `own_rel`.
- R9: A cycle with `ev_clr_we` high clears each event bit whose `ev_clr` bit is 1. When a bit is set and cleared in the same cycle, the set wins.
- R10: `irq` is high exactly when an event bit and its `irq_mask` bit (bit 0 babble, bit 1 frame) are both 1.
- R11: `rx_sof`, `rx_dv` and `rx_eof` are ignored during the status-write and release cycles. After release, the unit is idle and accepts the next `rx_sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sof | input | 1 | First byte of a frame (with rx_dv) |
| rx_dv | input | 1 | Byte valid strobe |
| rx_eof | input | 1 | Last byte of a frame (with rx_dv) |
| max_len | input | LEN_W | Maximum frame length in bytes |
| irq_mask | input | 2 | Interrupt enables: bit 0 babble, bit 1 frame |
| ev_clr_we | input | 1 | Event clear strobe |
| ev_clr | input | 2 | Write-one-to-clear pattern for events |
| st_wr | output | 1 | Descriptor status write strobe |
| st_len | output | LEN_W | Frame length in bytes |
| st_last | output | 1 | Last-in-frame flag |
| st_long | output | 1 | Frame exceeded max_len |
| own_rel | output | 1 | Clear empty bit, returning the buffer to software |
| events | output | 2 | Sticky events: bit 0 babble, bit 1 frame received |
| irq | output | 1 | Masked interrupt |

## Verification
The bench covers frames of exactly the maximum length and of one byte more. A design with an off-by-one comparison flags the first case or misses the second. A long frame has its babble event cleared partway through: a unit that compares with "greater than" on every byte re-raises the event. A 70000-byte frame with the maximum set to the top count checks that the counter saturates rather than wraps, and that the ceiling alone does not raise a false babble. The bench also clears an event in the very cycle it is set, to catch a clear that wins over the set. It drives start and data bytes during the hand-back cycles to catch a second write or a corrupted length.

// File: rtl/rx_frame_status.sv
module rx_frame_status #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_sof,
  input  logic             rx_dv,
  input  logic             rx_eof,
  input  logic [LEN_W-1:0] max_len,
  input  logic [1:0]       irq_mask,
  input  logic             ev_clr_we,
  input  logic [1:0]       ev_clr,
  output logic             st_wr,
  output logic [LEN_W-1:0] st_len,
  output logic             st_last,
  output logic             st_long,
  output logic             own_rel,
  output logic [1:0]       events,
  output logic             irq
);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_WR, S_REL} state_t;

  state_t           st;
  logic [LEN_W-1:0] cnt;
  logic             lng;
  logic [1:0]       ev;

  wire              open_w = (st == S_IDLE) || (st == S_RX);
  wire              take   = open_w && rx_dv && (rx_sof || st == S_RX);
  wire [LEN_W-1:0]  base   = rx_sof ? '0 : cnt;
  wire              at_top = &base;
  wire              over   = take && (rx_sof || !lng) && (base == max_len) && !at_top;
  wire [1:0]        ev_set = {st == S_REL, over};
  wire [1:0]        ev_clr_eff = ev_clr_we ? ev_clr : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      lng <= 1'b0;
      ev  <= 2'b00;
    end else begin
      ev <= (ev & ~ev_clr_eff) | ev_set;
      if (take) begin
        cnt <= at_top ? base : base + 1'b1;
        lng <= rx_sof ? over : (lng | over);
      end
      case (st)
        S_IDLE, S_RX: if (take) st <= rx_eof ? S_WR : S_RX;
        S_WR:         st <= S_REL;
        default:      st <= S_IDLE;
      endcase
    end
  end

  assign st_wr   = (st == S_WR);
  assign st_last = (st == S_WR);
  assign own_rel = (st == S_REL);
  assign st_len  = cnt;
  assign st_long = lng;
  assign events  = ev;
  assign irq     = |(ev & irq_mask);

endmodule

module rx_frame_status_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_sof,
  input logic             rx_dv,
  input logic             st_wr,
  input logic [LEN_W-1:0] st_len,
  input logic             st_long,
  input logic             own_rel,
  input logic [1:0]       events
);

  a_r7_release_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> (own_rel && !st_wr));

  a_r8_event_follows_release: assert property (@(posedge clk) disable iff (!rst_n)
    own_rel |=> events[1]);

  a_r11_no_write_during_release: assert property (@(posedge clk) disable iff (!rst_n)
    own_rel |-> !st_wr);

  a_r4_babble_marks_long: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(events[0]) |-> st_long);

  a_r5_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ((&st_len) && !(rx_sof && rx_dv)) |=> (&st_len));

endmodule

bind rx_frame_status rx_frame_status_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/rx_frame_status_tb.sv
module rx_frame_status_tb;
  localparam int CLK_P = 10;
  localparam int LW = 16;
  localparam int TOP = 65535;

  logic clk = 0, rst_n = 0;
  logic sof = 0, dv = 0, eof = 0, clr_we = 0;
  logic [1:0] clr = 0, mask = 0;
  logic [LW-1:0] max_len = 16'd10;
  logic st_wr, st_last, st_long, own_rel, irq;
  logic [LW-1:0] st_len;
  logic [1:0] events;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int mst = 0, mcnt = 0, mlong = 0, mev = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_frame_status #(.LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_sof(sof), .rx_dv(dv), .rx_eof(eof),
    .max_len(max_len), .irq_mask(mask), .ev_clr_we(clr_we), .ev_clr(clr),
    .st_wr(st_wr), .st_len(st_len), .st_last(st_last), .st_long(st_long),
    .own_rel(own_rel), .events(events), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    int base, over, take, setv;
    cyc++;
    if (!rst_n) begin
      mst = 0; mcnt = 0; mlong = 0; mev = 0;
    end else begin
      take = (mst < 2) && dv && (sof || mst == 1);
      base = sof ? 0 : mcnt;
      over = take && (sof || !mlong) && base == int'(max_len) && base != TOP;
      setv = ((mst == 3) ? 2 : 0) | (over ? 1 : 0);
      mev = (mev & ~(clr_we ? int'(clr) : 0) & 3) | setv;
      if (take) begin
        mcnt = (base == TOP) ? base : base + 1;
        mlong = sof ? over : (mlong | over);
      end
      if (mst < 2) begin
        if (take) mst = eof ? 2 : 1;
      end else if (mst == 2) mst = 3;
      else mst = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 st_wr", st_wr, mst == 2);
      chk("R6 st_last", st_last, mst == 2);
      chk("R7 own_rel", own_rel, mst == 3);
      chk("R2 st_len", st_len, mcnt);
      chk("R4 st_long", st_long, mlong);
      chk("R9 events", events, mev);
      chk("R10 irq", irq, (mev & int'(mask)) != 0);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic drv(input logic s, input logic d, input logic e, input logic w, input logic [1:0] c);
    @(posedge clk); #1;
    sof = s; dv = d; eof = e; clr_we = w; clr = c;
  endtask

  task automatic idle(); drv(0, 0, 0, 0, 2'b00); endtask

  task automatic frame(input int n);
    for (int i = 0; i < n; i++) drv(i == 0, 1, i == n - 1, 0, 2'b00);
    idle();
  endtask

  task automatic clear(input logic [1:0] c); drv(0, 0, 0, 1, c); idle(); endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 events", events, 0); chk("R1 irq", irq, 0);
    chk("R1 st_wr", st_wr, 0); chk("R1 st_len", st_len, 0);
    mask = 2'b11;

    frame(5);
    @(negedge clk); chk("R6 write", st_wr, 1); chk("R6 len", st_len, 5); chk("R6 long", st_long, 0);
    @(negedge clk); chk("R7 release", own_rel, 1); chk("R8 not yet", events, 0);
    @(negedge clk); chk("R8 frame event", events, 2); chk("R10 irq", irq, 1);

    drv(0, 1, 0, 0, 0); drv(0, 1, 1, 0, 0); idle();
    @(negedge clk); chk("R2 stray dv", st_len, 5); chk("R2 no write", st_wr, 0);

    clear(2'b10);
    @(negedge clk); chk("R9 w1c", events, 0);

    max_len = 16'd8; frame(8);
    repeat (3) @(negedge clk);
    chk("R4 exact max long", st_long, 0); chk("R4 exact max event", events, 2);
    clear(2'b11);

    max_len = 16'd4;
    for (int i = 0; i < 20; i++) drv(i == 0, 1, i == 19, i == 8, 2'b01);
    idle();
    @(negedge clk);
    chk("R3 len kept", st_len, 20); chk("R4 long", st_long, 1);
    chk("R4 no repeat", events[0], 0);
    repeat (2) @(negedge clk); clear(2'b11);

    max_len = 16'd4; frame(5);
    repeat (3) @(negedge clk); chk("R4 one past", events, 3);
    clear(2'b11);

    mask = 2'b01; frame(3);
    repeat (3) @(negedge clk); chk("R10 masked", irq, 0);
    clear(2'b11); mask = 2'b11;

    for (int i = 0; i < 3; i++) drv(i == 0, 1, i == 2, 0, 2'b00);
    drv(1, 1, 0, 0, 0); drv(1, 1, 1, 1, 2'b10); idle();
    @(negedge clk); chk("R9 set wins", events[1], 1); chk("R11 len held", st_len, 3);
    chk("R11 idle", st_wr, 0);
    clear(2'b11);

    drv(1, 1, 1, 0, 0); idle();
    @(negedge clk); chk("R2 single byte", st_len, 1);
    repeat (3) idle();

    drv(1, 1, 0, 0, 0); drv(0, 1, 0, 0, 0); drv(1, 1, 0, 0, 0); drv(0, 1, 1, 0, 0); idle();
    @(negedge clk); chk("R2 restart", st_len, 2);
    repeat (3) idle(); clear(2'b11);

    max_len = 16'hFFFF; frame(70000);
    @(negedge clk); chk("R5 saturate", st_len, TOP); chk("R5 no babble", st_long, 0);
    repeat (3) idle();
    chk("R5 event", events, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule